// File: doc/BRIEF.md
# Endian-Aware Load/Store Lane Steering Unit

This unit sits between a processor's load/store pipeline and a 32-bit cache data array. For each request it takes a byte address, an access size (byte, halfword or word), a store flag, store data and a run-time byte-order bit. One clock later it presents a word address, a byte-lane write mask, store data moved onto the lanes the access covers, the corrected byte offset, and a flag for a misaligned store. An address that does not suit its size is quietly brought into line: the low offset bits the size does not allow are cleared. Only stores raise the misalignment flag. What happens after the flag is raised is left to the surrounding pipeline.

A separate return path takes a 32-bit word read from the array, together with the size, offset, signedness and byte order of the original load. It picks out the addressed byte or halfword and widens it to 32 bits, with zero or sign extension. Byte and halfword accesses take exactly as many cycles as word accesses.

A second request address can be offered in the same cycle as the first. The unit reports a bank conflict when both requests are valid and address bits 4..2 match. The pipeline uses this to hold the second request for a cycle.

Top module: `lsu_lane_steer`

## Requirements
- R1: One cycle after a valid request, `q_addr` equals the request address with bits 1..0 cleared. `q_boff` is the offset corrected for size: unchanged for a byte (size code 00), bit 0 cleared for a halfword (code 01), and 00 for a word (code 10). Code 11 is treated as a word in every respect.
- R2: With `big_endian` low, memory byte offset k sits on data lane k (lane k is bits 8k+7..8k). A byte store enables the single lane at the corrected offset. A halfword store enables lanes off and off+1 and places data bits 7..0 on the lower lane.
- R3: With `big_endian` high, memory byte offset k sits on lane 3-k. A byte store at offset 0 enables lane 3 (bits 31..24). A halfword store at offset 0 enables lanes 3 and 2 with data bits 15..8 on lane 3. At offset 2 it enables lanes 1 and 0.
- R4: A word store enables all four lanes and passes the store data through unchanged. A load request produces a lane mask of 0000 and store data of zero. Lanes that a store does not enable carry zero.
- R5: `q_mis_store` is raised one cycle after a valid store whose address is not a multiple of its size. It is never raised for loads, for aligned stores or for byte stores.
- R6: On the return path, one cycle after `rd_valid`, `ld_data` holds the byte or halfword selected by the offset (corrected as in R1) and the byte order (same lane mapping as R2/R3), zero-extended when `rd_signed` is low. Word loads return the word unchanged.
- R7: With `rd_signed` high, byte and halfword load results are sign-extended from their top bit.
- R8: `bank_conflict` is raised one cycle after a cycle in which both `a_valid` and `b_valid` are high and address bits 4..2 of the two requests are equal. Otherwise it is low.
- R9: Every output is registered with a one-cycle latency, whatever the size. Requests may arrive every cycle. When no request is valid, the request outputs (`q_valid`, `q_addr`, `q_boff`, `q_be`, `q_wdata`, `q_mis_store`) are zero. When `rd_valid` is low, `ld_valid` and `ld_data` are zero.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| a_valid | input | 1 | Primary request valid |
| a_addr | input | 32 | Primary request byte address |
| a_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| a_store | input | 1 | 1 store, 0 load |
| a_wdata | input | 32 | Store data, right-justified |
| b_valid | input | 1 | Second request valid |
| b_addr | input | 32 | Second request byte address |
| rd_valid | input | 1 | Returned word valid |
| rd_word | input | 32 | Word read from the data array |
| rd_size | input | 2 | Size of the returning load |
| rd_off | input | 2 | Byte offset of the returning load |
| rd_signed | input | 1 | Sign-extend the load result |
| q_valid | output | 1 | Registered request valid |
| q_addr | output | 32 | Word-aligned address |
| q_boff | output | 2 | Size-corrected byte offset |
| q_be | output | 4 | Byte-lane write enables |
| q_wdata | output | 32 | Lane-steered store data |
| q_mis_store | output | 1 | Misaligned-store exception flag |
| bank_conflict | output | 1 | Both requests address the same bank |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The embedded properties check the following on every cycle:
- the output address always lands on a word boundary and follows the request address;
- loads never enable a lane, and word stores enable all four;
- the lane mask never takes a width other than one, two or four lanes;
- the misalignment flag stays quiet without a store;
- the bank flag follows the bit 4..2 comparison;
- an unsigned byte load leaves the upper 24 bits clear.

Which lane a given offset lands on in each byte order, the exact bytes placed and extracted, and the sign of widened values depend on the data. Only the scoreboard scenarios can show them. The bench sweeps every size, offset and byte order on both paths, including misaligned stores and loads and the reserved size code.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  // Offset with the bits forbidden by the size forced to zero
  function automatic logic [1:0] fix_offset(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: fix_offset = off;
      SZ_HALF: fix_offset = {off[1], 1'b0};
      default: fix_offset = 2'b00;
    endcase
  endfunction

  // Lowest data lane the access occupies
  function automatic logic [1:0] low_lane(input logic [1:0] sz, input logic [1:0] off,
                                          input logic be_mode);
    case (sz)
      SZ_BYTE: low_lane = be_mode ? (2'd3 - off) : off;
      SZ_HALF: low_lane = be_mode ? (2'd2 - off) : off;
      default: low_lane = 2'd0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lane);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << lane;
      SZ_HALF: lane_mask = 4'b0011 << lane;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] place_data(input logic [1:0] sz, input logic [1:0] lane,
                                               input logic [DW-1:0] w);
    case (sz)
      SZ_BYTE: place_data = {24'b0, w[7:0]}  << {lane, 3'b000};
      SZ_HALF: place_data = {16'b0, w[15:0]} << {lane, 3'b000};
      default: place_data = w;
    endcase
  endfunction

  function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: is_misaligned = 1'b0;
      SZ_HALF: is_misaligned = off[0];
      default: is_misaligned = |off;
    endcase
  endfunction

  function automatic logic [DW-1:0] extract(input logic [1:0] sz, input logic [1:0] lane,
                                            input logic [DW-1:0] w, input logic sgn);
    logic [DW-1:0] sh;
    sh = w >> {lane, 3'b000};
    case (sz)
      SZ_BYTE: extract = {{24{sgn & sh[7]}}, sh[7:0]};
      SZ_HALF: extract = {{16{sgn & sh[15]}}, sh[15:0]};
      default: extract = w;
    endcase
  endfunction

endpackage

// File: rtl/lsa_store_path.sv
module lsa_store_path
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              store,
  input  logic [DW-1:0]     wdata,
  input  logic              be_mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic [1:0]        boff,
  output logic [LANES-1:0]  lane_en,
  output logic [DW-1:0]     lane_data,
  output logic              mis_store
);
  logic [1:0] lane_lo;
  logic       off_bad;

  assign boff      = fix_offset(size, addr[1:0]);
  assign lane_lo   = low_lane(size, boff, be_mode);
  assign off_bad   = is_misaligned(size, addr[1:0]);
  assign word_addr = {addr[ADDR_W-1:2], 2'b00};
  assign lane_en   = store ? lane_mask(size, lane_lo) : '0;
  assign lane_data = store ? place_data(size, lane_lo, wdata) : '0;
  assign mis_store = store & off_bad;
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
  import lsa_pkg::*;
(
  input  logic [DW-1:0] word,
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic          sgn,
  input  logic          be_mode,
  output logic [DW-1:0] result
);
  logic [1:0] off_fixed;
  logic [1:0] lane_lo;

  assign off_fixed = fix_offset(size, off);
  assign lane_lo   = low_lane(size, off_fixed, be_mode);
  assign result    = extract(size, lane_lo, word, sgn);
endmodule

// File: rtl/lsa_bank_cmp.sv
module lsa_bank_cmp #(
  parameter int ADDR_W   = 32,
  parameter int BANK_LSB = 2,
  parameter int BANK_W   = 3
) (
  input  logic              a_v,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_v,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              clash
);
  localparam int BANK_MSB = BANK_LSB + BANK_W - 1;
  logic same_bank;

  assign same_bank = (a_addr[BANK_MSB:BANK_LSB] == b_addr[BANK_MSB:BANK_LSB]);
  assign clash     = a_v & b_v & same_bank;
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BANK_LSB = 2,
  parameter int BANK_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              a_valid,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [1:0]        a_size,
  input  logic              a_store,
  input  logic [DW-1:0]     a_wdata,
  input  logic              b_valid,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              rd_valid,
  input  logic [DW-1:0]     rd_word,
  input  logic [1:0]        rd_size,
  input  logic [1:0]        rd_off,
  input  logic              rd_signed,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [1:0]        q_boff,
  output logic [LANES-1:0]  q_be,
  output logic [DW-1:0]     q_wdata,
  output logic              q_mis_store,
  output logic              bank_conflict,
  output logic              ld_valid,
  output logic [DW-1:0]     ld_data
);
  localparam int BANK_MSB = BANK_LSB + BANK_W - 1;

  // Named internal events
  logic [ADDR_W-1:0] st_addr;
  logic [1:0]        st_boff;
  logic [LANES-1:0]  st_en;
  logic [DW-1:0]     st_data;
  logic              st_mis;
  logic              clash_now;
  logic [DW-1:0]     ld_now;

  lsa_store_path #(.ADDR_W(ADDR_W)) u_store (
    .addr(a_addr), .size(a_size), .store(a_store), .wdata(a_wdata),
    .be_mode(big_endian), .word_addr(st_addr), .boff(st_boff),
    .lane_en(st_en), .lane_data(st_data), .mis_store(st_mis)
  );

  lsa_load_path u_load (
    .word(rd_word), .size(rd_size), .off(rd_off), .sgn(rd_signed),
    .be_mode(big_endian), .result(ld_now)
  );

  lsa_bank_cmp #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)) u_bank (
    .a_v(a_valid), .a_addr(a_addr), .b_v(b_valid), .b_addr(b_addr), .clash(clash_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid       <= 1'b0;
      q_addr        <= '0;
      q_boff        <= '0;
      q_be          <= '0;
      q_wdata       <= '0;
      q_mis_store   <= 1'b0;
      bank_conflict <= 1'b0;
      ld_valid      <= 1'b0;
      ld_data       <= '0;
    end else begin
      q_valid       <= a_valid;
      q_addr        <= a_valid ? st_addr : '0;
      q_boff        <= a_valid ? st_boff : '0;
      q_be          <= a_valid ? st_en   : '0;
      q_wdata       <= a_valid ? st_data : '0;
      q_mis_store   <= a_valid & st_mis;
      bank_conflict <= clash_now;
      ld_valid      <= rd_valid;
      ld_data       <= rd_valid ? ld_now : '0;
    end
  end

  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> q_addr[1:0] == 2'b00); // R1
  AST_ADDR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |=> q_addr[ADDR_W-1:2] == $past(a_addr[ADDR_W-1:2])); // R1
  AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (q_be != '0) |-> ($countones(q_be) == 1 || $countones(q_be) == 2 || $countones(q_be) == 4)); // R2
  AST_NO_LANES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_store) |=> (q_be == '0 && q_wdata == '0)); // R4
  AST_WORD_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_store && a_size[1]) |=> q_be == 4'hF); // R4
  AST_MIS_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && a_store) |=> !q_mis_store); // R5
  AST_UNSIGNED_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_signed && rd_size == SZ_BYTE) |=> ld_data[DW-1:8] == '0); // R6
  AST_BANK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && a_addr[BANK_MSB:BANK_LSB] == b_addr[BANK_MSB:BANK_LSB]) |=> bank_conflict); // R8
  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && b_valid) |=> !bank_conflict); // R8
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |=> q_valid); // R9

endmodule

// File: tb/sim_lsu_lane_steer.sv
`timescale 1ns/1ps
module sim_lsu_lane_steer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        a_valid = 1'b0;
  logic [31:0] a_addr = '0;
  logic [1:0]  a_size = '0;
  logic        a_store = 1'b0;
  logic [31:0] a_wdata = '0;
  logic        b_valid = 1'b0;
  logic [31:0] b_addr = '0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_word = '0;
  logic [1:0]  rd_size = '0;
  logic [1:0]  rd_off = '0;
  logic        rd_signed = 1'b0;
  logic        q_valid, q_mis_store, bank_conflict, ld_valid;
  logic [31:0] q_addr, q_wdata, ld_data;
  logic [1:0]  q_boff;
  logic [3:0]  q_be;

  always #5 clk = ~clk;

  lsu_lane_steer u0 (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .a_valid(a_valid), .a_addr(a_addr), .a_size(a_size), .a_store(a_store), .a_wdata(a_wdata),
    .b_valid(b_valid), .b_addr(b_addr),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_size(rd_size), .rd_off(rd_off), .rd_signed(rd_signed),
    .q_valid(q_valid), .q_addr(q_addr), .q_boff(q_boff), .q_be(q_be), .q_wdata(q_wdata),
    .q_mis_store(q_mis_store), .bank_conflict(bank_conflict), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  typedef struct {
    logic        valid;
    logic [31:0] addr;
    logic [1:0]  boff;
    logic [3:0]  be;
    logic [31:0] data;
    logic        mis;
    logic        conf;
    logic        ldv;
    logic [31:0] ldd;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int n_checks = 0;
  int n_fail = 0;

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int lane_of(input int k, input logic bem);
    return bem ? 3 - k : k;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues its expected outcome
  task automatic step(input logic av, input logic [31:0] ad, input logic [1:0] sz, input logic st,
                      input logic [31:0] wd, input logic bv, input logic [31:0] bd, input logic bem,
                      input logic rv, input logic [31:0] rw, input logic [1:0] rsz, input logic [1:0] rof,
                      input logic rsg, input string tag);
    exp_t e;
    int n, off;
    @(negedge clk);
    a_valid = av; a_addr = ad; a_size = sz; a_store = st; a_wdata = wd;
    b_valid = bv; b_addr = bd; big_endian = bem;
    rd_valid = rv; rd_word = rw; rd_size = rsz; rd_off = rof; rd_signed = rsg;
    e.tag = tag;
    n = nbytes(sz);
    off = int'(ad[1:0]) / n * n;
    e.valid = av;
    e.addr  = av ? (ad & 32'hFFFF_FFFC) : 32'h0;
    e.boff  = av ? 2'(off) : 2'd0;
    e.be    = 4'h0;
    e.data  = 32'h0;
    e.mis   = av && st && (int'(ad[1:0]) % n != 0);
    if (av && st) begin
      for (int i = 0; i < n; i++) begin
        int ln, src;
        ln  = lane_of(off + i, bem);
        src = bem ? (n - 1 - i) : i;
        e.be[ln] = 1'b1;
        e.data[ln*8 +: 8] = wd[src*8 +: 8];
      end
    end
    e.conf = av && bv && (((ad >> 2) & 7) == ((bd >> 2) & 7));
    e.ldv  = rv;
    e.ldd  = 32'h0;
    if (rv) begin
      int rn, roffx;
      rn = nbytes(rsz);
      roffx = int'(rof) / rn * rn;
      for (int i = 0; i < rn; i++) begin
        int dst;
        dst = bem ? (rn - 1 - i) : i;
        e.ldd[dst*8 +: 8] = rw[lane_of(roffx + i, bem)*8 +: 8];
      end
      if (rsg && rn < 4 && e.ldd[rn*8-1]) begin
        for (int j = rn * 8; j < 32; j++) e.ldd[j] = 1'b1;
      end
    end
    expq.push_back(e);
  endtask

  // Monitor: pops and compares after each active edge
  always @(posedge clk) begin
    #2;
    if (rst_n && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk({e.tag, "/R9"}, "q_valid", {31'b0, q_valid}, {31'b0, e.valid});
      chk({e.tag, "/R1"}, "q_addr", q_addr, e.addr);
      chk({e.tag, "/R1"}, "q_boff", {30'b0, q_boff}, {30'b0, e.boff});
      chk(e.tag, "q_be", {28'b0, q_be}, {28'b0, e.be});
      chk(e.tag, "q_wdata", q_wdata, e.data);
      chk({e.tag, "/R5"}, "q_mis_store", {31'b0, q_mis_store}, {31'b0, e.mis});
      chk({e.tag, "/R8"}, "bank_conflict", {31'b0, bank_conflict}, {31'b0, e.conf});
      chk({e.tag, "/R9"}, "ld_valid", {31'b0, ld_valid}, {31'b0, e.ldv});
      chk(e.tag, "ld_data", ld_data, e.ldd);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R10: outputs zero during reset, even with active inputs
    a_valid = 1'b1; a_store = 1'b1; a_size = 2'd2; a_wdata = 32'hDEADBEEF; rd_valid = 1'b1;
    b_valid = 1'b1; rd_word = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R10", "q_valid", {31'b0, q_valid}, 32'h0);
    chk("R10", "q_be", {28'b0, q_be}, 32'h0);
    chk("R10", "q_wdata", q_wdata, 32'h0);
    chk("R10", "bank_conflict", {31'b0, bank_conflict}, 32'h0);
    chk("R10", "ld_data", ld_data, 32'h0);
    chk("R10", "ld_valid", {31'b0, ld_valid}, 32'h0);
    a_valid = 1'b0; rd_valid = 1'b0; b_valid = 1'b0;
    rst_n = 1'b1;

    // R2 / R4: little-endian stores, every size and offset
    for (int o = 0; o < 4; o++)
      step(1, 32'h1000_0100 + 32'(o), 2'd0, 1, 32'hA1B2C3D4, 0, 0, 0, 0, 0, 0, 0, 0, "R2_le_byte");
    step(1, 32'h1000_0200, 2'd1, 1, 32'h5566_7788, 0, 0, 0, 0, 0, 0, 0, 0, "R2_le_half0");
    step(1, 32'h1000_0202, 2'd1, 1, 32'h5566_7788, 0, 0, 0, 0, 0, 0, 0, 0, "R2_le_half2");
    step(1, 32'h1000_0300, 2'd2, 1, 32'h0123_4567, 0, 0, 0, 0, 0, 0, 0, 0, "R4_le_word");
    // R3 / R4: big-endian stores
    for (int o = 0; o < 4; o++)
      step(1, 32'h2000_0040 + 32'(o), 2'd0, 1, 32'h0000_0099, 0, 0, 1, 0, 0, 0, 0, 0, "R3_be_byte");
    step(1, 32'h2000_0080, 2'd1, 1, 32'h0000_ABCD, 0, 0, 1, 0, 0, 0, 0, 0, "R3_be_half0");
    step(1, 32'h2000_0082, 2'd1, 1, 32'h0000_ABCD, 0, 0, 1, 0, 0, 0, 0, 0, "R3_be_half2");
    step(1, 32'h2000_0084, 2'd2, 1, 32'hCAFE_F00D, 0, 0, 1, 0, 0, 0, 0, 0, "R4_be_word");
    step(1, 32'h2000_0088, 2'd3, 1, 32'h1357_9BDF, 0, 0, 1, 0, 0, 0, 0, 0, "R4_size3_word");
    // R5: misaligned stores forced into line and flagged
    step(1, 32'h3000_0001, 2'd1, 1, 32'h0000_1122, 0, 0, 0, 0, 0, 0, 0, 0, "R5_half_off1");
    step(1, 32'h3000_0003, 2'd1, 1, 32'h0000_3344, 0, 0, 1, 0, 0, 0, 0, 0, "R5_half_off3");
    for (int o = 1; o < 4; o++)
      step(1, 32'h3000_0010 + 32'(o), 2'd2, 1, 32'h89AB_CDEF, 0, 0, o[0], 0, 0, 0, 0, 0, "R5_word_mis");
    step(1, 32'h3000_0023, 2'd3, 1, 32'h0F0F_0F0F, 0, 0, 0, 0, 0, 0, 0, 0, "R5_size3_mis");
    // R4 / R5: loads drive no lanes and never flag, even misaligned
    step(1, 32'h4000_0003, 2'd2, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R4_load_word_mis");
    step(1, 32'h4000_0001, 2'd1, 0, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 0, 0, "R4_load_half_mis");
    // R9: idle cycle clears request outputs
    step(0, 32'h4000_0005, 2'd0, 1, 32'hFFFF_FFFF, 1, 32'h4000_0005, 0, 0, 0, 0, 0, 0, "R9_idle");
    // R8: bank conflict cases
    step(1, 32'h5000_0014, 2'd2, 0, 0, 1, 32'h7700_0034, 0, 0, 0, 0, 0, 0, "R8_same_bank");
    step(1, 32'h5000_0014, 2'd2, 0, 0, 1, 32'h5000_0018, 0, 0, 0, 0, 0, 0, "R8_diff_bank");
    step(1, 32'h5000_001C, 2'd0, 1, 32'h0000_0055, 1, 32'h5000_001F, 1, 0, 0, 0, 0, 0, "R8_same_word");
    step(1, 32'h5000_0000, 2'd2, 0, 0, 0, 32'h5000_0000, 0, 0, 0, 0, 0, 0, "R8_b_idle");
    step(1, 32'h5000_0020, 2'd2, 0, 0, 1, 32'h5000_0000, 0, 0, 0, 0, 0, 0, "R8_bit5_only");
    // R6 / R7: load extraction, both byte orders, signed and unsigned
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int o = 0; o < 4; o++)
          step(0, 0, 0, 0, 0, 0, 0, m[0], 1, 32'h8A7B_F01C, 2'd0, 2'(o), s[0], s[0] ? "R7_byte" : "R6_byte");
        for (int o = 0; o < 4; o++)
          step(0, 0, 0, 0, 0, 0, 0, m[0], 1, 32'h8A7B_F01C, 2'd1, 2'(o), s[0], s[0] ? "R7_half" : "R6_half");
        step(0, 0, 0, 0, 0, 0, 0, m[0], 1, 32'h8A7B_F01C, 2'd2, 2'd3, s[0], "R6_word");
      end
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_7F80, 2'd1, 2'd0, 1, "R7_half_pos");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h7F80_0000, 2'd0, 2'd0, 1, "R7_byte_pos_be");
    // R9: both paths busy in the same cycles, back to back
    step(1, 32'h6000_0002, 2'd1, 1, 32'h0000_BEEF, 1, 32'h6000_0042, 1, 1, 32'h1234_5678, 2'd1, 2'd2, 1, "R9_both");
    step(1, 32'h6000_0005, 2'd0, 1, 32'h0000_0011, 1, 32'h6000_0009, 0, 1, 32'hF234_56F8, 2'd0, 2'd1, 1, "R9_both");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 2'd0, 2'd1, 1, "R9_quiet");
    repeat (3) @(posedge clk);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule